// File: doc/BRIEF.md
# Banked 32-to-1 Bit Selector

This block picks one bit out of a 32-bit data word and presents that bit together with its inverse. It has no clock and no storage. The output follows the inputs after gate delay only.

The word is split into four groups of eight bits. Each group has its own 8-input leaf selector with an active-low gate. A 2-to-4 decoder opens exactly one gate, and the decoder is driven by the two high select bits. The three low select bits go to all four leaves. A closed leaf forces its true output to 0 and its inverted output to 1. The result is formed as a NAND over the inverted leaf outputs, which is the same as an OR over the true outputs. A closed leaf therefore adds nothing to the result.

A global enable input can close all four gates at once. The result is then 0 and its inverse is 1.

Top module: `banked_mux`

## Requirements
- R1: With `enable` high, `y` equals bit `sel` of `data`, for every one of the 32 select values.
- R2: `y_n` is always the logical inverse of `y`.
- R3: With `enable` low, `y` is 0 and `y_n` is 1 for any `data` and `sel`.
- R4: `sel[4:3]` chooses group k, which holds data bits 8k to 8k+7. `sel[2:0]` chooses the bit inside that group, counted from the group's least significant bit.
- R5: With `enable` high, exactly one leaf gate is open. With `enable` low, no leaf gate is open.
- R6: A closed leaf drives 0 on its true output and 1 on its inverted output. Data bits outside the selected group therefore have no effect on `y`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| data | input | 32 | Data word to select from |
| sel | input | 5 | Bit index: [4:3] picks the group, [2:0] picks the bit within it |
| enable | input | 1 | Global enable, active high |
| y | output | 1 | Selected bit |
| y_n | output | 1 | Inverse of the selected bit |

## Verification
Two functions overlap in every evaluation. The decoder closes three leaves, and the one open leaf passes its bit to the combining NAND. A fault in either function can therefore show up as an extra 1 or a lost 1 at `y`. The bench provokes this with walking-one and walking-zero words. In these words only the selected bit differs from all the bits in the closed leaves. Any leaking leaf, or a wrong group choice, flips `y` away from `data[sel]`. Each result is judged against `data[sel]`, which the bench computes itself from the inputs.

// File: rtl/banked_mux.sv
module banked_mux_leaf #(
  parameter int SEL_W = 3
) (
  input  logic [2**SEL_W-1:0] d,
  input  logic [SEL_W-1:0]    s,
  input  logic                gate_n,
  output logic                q,
  output logic                q_n
);
  assign q   = ~gate_n & d[s];
  assign q_n = ~q;
endmodule

module banked_mux #(
  parameter int LEAF_SEL_W = 3,
  parameter int BANK_SEL_W = 2,
  localparam int SEL_W  = LEAF_SEL_W + BANK_SEL_W,
  localparam int LEAF_N = 2**LEAF_SEL_W,
  localparam int LEAVES = 2**BANK_SEL_W,
  localparam int DATA_W = LEAF_N * LEAVES
) (
  input  logic [DATA_W-1:0] data,
  input  logic [SEL_W-1:0]  sel,
  input  logic              enable,
  output logic              y,
  output logic              y_n
);
  logic [LEAVES-1:0] leaf_gate_n;
  logic [LEAVES-1:0] leaf_q;
  logic [LEAVES-1:0] leaf_qn;

  always_comb begin
    leaf_gate_n = '1;
    if (enable) leaf_gate_n[sel[SEL_W-1:LEAF_SEL_W]] = 1'b0;
  end

  for (genvar k = 0; k < LEAVES; k++) begin : g_leaf
    banked_mux_leaf #(.SEL_W(LEAF_SEL_W)) u_leaf (
      .d      (data[k*LEAF_N +: LEAF_N]),
      .s      (sel[LEAF_SEL_W-1:0]),
      .gate_n (leaf_gate_n[k]),
      .q      (leaf_q[k]),
      .q_n    (leaf_qn[k])
    );
  end

  assign y   = ~&leaf_qn;
  assign y_n = ~y;
endmodule

// File: rtl/banked_mux_chk.sv
module banked_mux_chk #(
  parameter int LEAF_SEL_W = 3,
  parameter int BANK_SEL_W = 2,
  localparam int SEL_W  = LEAF_SEL_W + BANK_SEL_W,
  localparam int LEAVES = 2**BANK_SEL_W,
  localparam int DATA_W = (2**LEAF_SEL_W) * LEAVES
) (
  input logic [DATA_W-1:0] data,
  input logic [SEL_W-1:0]  sel,
  input logic              enable,
  input logic              y,
  input logic              y_n,
  input logic [LEAVES-1:0] leaf_gate_n,
  input logic [LEAVES-1:0] leaf_q,
  input logic [LEAVES-1:0] leaf_qn
);
  always_comb begin
    if (enable) p_pick_r1: assert (y == data[sel]);
    p_inverse_r2: assert (y_n == ~y);
    if (!enable) p_idle_r3: assert (!y && y_n);
    if (enable) p_one_gate_r5: assert ($countones(~leaf_gate_n) == 1);
    else p_no_gate_r5: assert ($onehot0(~leaf_gate_n) && leaf_gate_n == '1);
    if (enable) p_group_r4: assert (!leaf_gate_n[sel[SEL_W-1:LEAF_SEL_W]]);
    p_quiet_r6: assert ((leaf_q & ~leaf_gate_n) == leaf_q && (leaf_qn | ~leaf_gate_n) == '1);
  end
endmodule

bind banked_mux banked_mux_chk #(.LEAF_SEL_W(LEAF_SEL_W), .BANK_SEL_W(BANK_SEL_W)) u_chk (
  .data(data), .sel(sel), .enable(enable), .y(y), .y_n(y_n),
  .leaf_gate_n(leaf_gate_n), .leaf_q(leaf_q), .leaf_qn(leaf_qn)
);

// File: tb/banked_mux_test.sv
module banked_mux_test;
  logic        clk = 1'b0;
  logic [31:0] data;
  logic [4:0]  sel;
  logic        enable;
  logic        y, y_n;
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  banked_mux uut (.data(data), .sel(sel), .enable(enable), .y(y), .y_n(y_n));

  // {enable, sel, data, expected y}
  localparam logic [38:0] VEC [8] = '{
    {1'b1, 5'd0,  32'h0000_0001, 1'b1},
    {1'b1, 5'd31, 32'h8000_0000, 1'b1},
    {1'b1, 5'd31, 32'h7FFF_FFFF, 1'b0},
    {1'b1, 5'd8,  32'h0000_0100, 1'b1},
    {1'b1, 5'd7,  32'hFFFF_FF7F, 1'b0},
    {1'b0, 5'd5,  32'hFFFF_FFFF, 1'b0},
    {1'b1, 5'd16, 32'h0001_0000, 1'b1},
    {1'b1, 5'd23, 32'hFF7F_FFFF, 1'b0}
  };

  task automatic apply(input logic [31:0] d, input logic [4:0] s, input logic e);
    @(negedge clk);
    data = d; sel = s; enable = e;
    #2;
  endtask

  task automatic check(input string req, input logic exp);
    checks++;
    if (y !== exp || y_n !== ~exp) begin
      fails++;
      $display("FAIL %s: y=%b y_n=%b expected y=%b y_n=%b (data=%h sel=%0d en=%b)",
               req, y, y_n, exp, ~exp, data, sel, enable);
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    data = '0; sel = '0; enable = 1'b0;
    // Idle state: R3
    apply(32'hFFFF_FFFF, 5'd0, 1'b0);
    check("R3 idle", 1'b0);

    for (int i = 0; i < 8; i++) begin
      apply(VEC[i][32:1], VEC[i][37:33], VEC[i][38]);
      check("R1/R4 vector", VEC[i][0]);
    end

    // Exhaustive random words, R1 and R2
    for (int r = 0; r < 20; r++) begin
      logic [31:0] w;
      w = $urandom;
      for (int s = 0; s < 32; s++) begin
        apply(w, 5'(s), 1'b1);
        check("R1 R2 random", w[s]);
      end
    end

    // Walking one / walking zero: R4 R5 R6
    for (int s = 0; s < 32; s++) begin
      apply(32'h1 << s, 5'(s), 1'b1);
      check("R6 walk1 hit", 1'b1);
      apply(~(32'h1 << s), 5'(s), 1'b1);
      check("R6 walk0 hit", 1'b0);
      apply(32'hFF << (8 * ((s / 8 + 1) % 4)), 5'(s), 1'b1);
      check("R4 R5 other group", 1'b0);
    end

    // Global disable over all select values: R3 R5
    for (int s = 0; s < 32; s++) begin
      apply(32'hFFFF_FFFF, 5'(s), 1'b0);
      check("R3 R5 disabled", 1'b0);
    end

    // Re-enable after disable
    apply(32'h0000_1000, 5'd12, 1'b1);
    check("R1 reenable", 1'b1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule